// File: doc/BRIEF.md
# Four-Channel ADPCM Serial Word Port

This block is the serial side of a four-channel ADPCM transcoder. It receives a serial stream of compressed words on a bit clock, splits each 8 kHz frame into four channel slots and presents the four assembled words in parallel once per frame. In the other direction it takes four parallel words at the start of each frame and shifts them out serially. Capture uses the falling bit-clock edge and launch uses the rising edge. The bit clock and frame sync are sampled by a faster system clock. This keeps the block in a single clock domain and lets the bit clock run anywhere from 128 kHz to 4096 kHz.

The word width comes from a 3-bit mode select: 4, 3 or 2 bits per channel. The mode is taken in only at a frame sync, so the width can move between 4 and 3 bits from one frame to the next without a reset, and no single frame ever mixes widths. A separate linear selector switches the port to 16-bit uniform PCM slots. In that mode, received words are 14-bit two's complement values sign-extended to 16 bits, and transmitted words are full 16-bit values.

Top module: `adpcm_serial_port`

## Requirements
- R1: The mode select sets the word width when linear is off: code 3'b000 gives 4 bits, 3'b001 gives 3 bits, 3'b010 gives 2 bits, and every other code gives 4 bits. Each channel slot is 4 bit times long. Channels follow in the order 0, 1, 2, 3, and each word is sent MSB first. Received channel c appears zero-extended on rxWords[16c+15:16c].
- R2: Serial input is sampled on falling bit-clock edges. A falling edge where the frame sync is high starts a frame, and the bit sampled on that edge is bit 0 of the frame.
- R3: Transmit words are taken from txWords (channel c at bits [16c+15:16c], using the low W bits) at the frame-start falling edge. Frame bit k is driven on serOut from the (k+1)th rising edge after the frame start.
- R4: In each slot, bit times after the first W are ignored on input and driven as 0 on output.
- R5: rxValid is a single-cycle pulse, raised exactly once per frame after the last slot bit has been sampled.
- R6: The mode select and linear selector are read only at a frame start. Changes in the middle of a frame have no effect on that frame.
- R7: The width may change between 4 and 3 bits (and any other width) on consecutive frames without a reset.
- R8: With the linear selector high, slots are 16 bit times long. Each received word equals its bits 13:0 sign-extended from bit 13, so incoming bits 15 and 14 are ignored.
- R9: In linear mode, each transmit word is sent as all 16 bits, MSB first.
- R10: After reset, rxValid, rxWords and serOut are 0. After the last bit time of a frame and until the next frame start, serOut is driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Active-low reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync, high across the falling edge of frame bit 0 |
| serIn | input | 1 | Serial compressed stream input |
| modeSel | input | 3 | Word width select |
| linSel | input | 1 | Linear 16-bit slot format select |
| txWords | input | 64 | Four transmit words, channel c at [16c+15:16c] |
| serOut | output | 1 | Serial stream output |
| rxWords | output | 64 | Four received words, channel c at [16c+15:16c] |
| rxValid | output | 1 | One-cycle pulse when rxWords is updated |

## Verification
The bench targets three risks: switching the mode in the middle of a frame, back-to-back frames that alternate between 4-bit and 3-bit widths, and unused codes that must fall back to 4 bits. A design that latched the mode too early would truncate or shift words within one frame. A design that counted slot bits wrongly would put a channel's bits into its neighbour's word. In linear frames, bits 15 and 14 are sent with values that disagree with bit 13, which exposes a design that does not sign-extend. The serial output is sampled after the last slot and in the trailing idle bit time, which catches stale bits from an off-by-one launch counter.

// File: rtl/adpcm_port_pkg.sv
package adpcm_port_pkg;
  localparam int NUM_CH     = 4;
  localparam int WORD_W     = 16;
  localparam int LIN_BITS   = 14;
  localparam int SLOT_ADPCM = 4;
  localparam int SLOT_LIN   = 16;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int POS_W      = $clog2(SLOT_LIN);
  localparam int WID_W      = POS_W + 1;
  localparam int CNT_W      = $clog2(NUM_CH * SLOT_LIN) + 1;
  localparam int LOG_ADPCM  = $clog2(SLOT_ADPCM);
  localparam int LOG_LIN    = $clog2(SLOT_LIN);

  typedef struct packed {
    logic              frameStart;
    logic              capture;
    logic              rxBit;
    logic [CH_W-1:0]   rxChan;
    logic              publish;
    logic              launch;
    logic              txOn;
    logic [CH_W-1:0]   txChan;
    logic [POS_W-1:0]  txIdx;
    logic              lin;
    logic [WID_W-1:0]  width;
  } ctl_t;

  function automatic logic [WID_W-1:0] widthOf(input logic [2:0] mode, input logic lin);
    if (lin)                 return WID_W'(SLOT_LIN);
    else if (mode == 3'b001) return WID_W'(3);
    else if (mode == 3'b010) return WID_W'(2);
    else                     return WID_W'(4);
  endfunction
endpackage

// File: rtl/adpcm_port_ctrl.sv
module adpcm_port_ctrl
  import adpcm_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclk,
  input  logic       fsync,
  input  logic       serIn,
  input  logic [2:0] modeSel,
  input  logic       linSel,
  output ctl_t       ctl
);
  logic [1:0] bclkQ, fsQ, diQ;
  logic       bclkD, running, curLin, pubD;
  logic [WID_W-1:0] curW;
  logic [CNT_W-1:0] rxCnt, txCnt;

  logic bclkS, fsS, fall, rise;
  assign bclkS = bclkQ[1];
  assign fsS   = fsQ[1];
  assign fall  = bclkD & ~bclkS;
  assign rise  = ~bclkD & bclkS;

  // receive side: effective frame parameters (a sync edge takes the new mode)
  logic             effLin, active, inFrame;
  logic [WID_W-1:0] newW, effW;
  logic [CNT_W-1:0] effCnt, rxBits, rxPosFull;
  logic [POS_W-1:0] rxPos;
  logic [CH_W-1:0]  rxChan;

  always_comb begin
    newW      = widthOf(modeSel, linSel);
    effLin    = fsS ? linSel : curLin;
    effW      = fsS ? newW : curW;
    effCnt    = fsS ? '0 : rxCnt;
    rxBits    = CNT_W'(NUM_CH) << (effLin ? LOG_LIN : LOG_ADPCM);
    rxPosFull = effCnt & ((CNT_W'(1) << (effLin ? LOG_LIN : LOG_ADPCM)) - CNT_W'(1));
    rxPos     = rxPosFull[POS_W-1:0];
    rxChan    = CH_W'(effCnt >> (effLin ? LOG_LIN : LOG_ADPCM));
    active    = fsS | running;
    inFrame   = active && (effCnt < rxBits);
  end

  // transmit side uses the frame parameters latched at the sync edge
  logic             txInFrame;
  logic [CNT_W-1:0] txBits, txPosFull;
  logic [WID_W-1:0] txPos, txIdxFull;

  always_comb begin
    txBits    = CNT_W'(NUM_CH) << (curLin ? LOG_LIN : LOG_ADPCM);
    txPosFull = txCnt & ((CNT_W'(1) << (curLin ? LOG_LIN : LOG_ADPCM)) - CNT_W'(1));
    txPos     = WID_W'(txPosFull);
    txIdxFull = curW - WID_W'(1) - txPos;
    txInFrame = running && (txCnt < txBits);
  end

  always_comb begin
    ctl            = '0;
    ctl.frameStart = fall & fsS;
    ctl.capture    = fall && inFrame && ({1'b0, rxPos} < effW);
    ctl.rxBit      = diQ[1];
    ctl.rxChan     = rxChan;
    ctl.publish    = pubD;
    ctl.launch     = rise;
    ctl.txOn       = txInFrame && (txPos < curW);
    ctl.txChan     = CH_W'(txCnt >> (curLin ? LOG_LIN : LOG_ADPCM));
    ctl.txIdx      = txIdxFull[POS_W-1:0];
    ctl.lin        = curLin;
    ctl.width      = curW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ <= '0; fsQ <= '0; diQ <= '0; bclkD <= 1'b0;
      running <= 1'b0; curLin <= 1'b0; curW <= WID_W'(4);
      rxCnt <= '0; txCnt <= '0; pubD <= 1'b0;
    end else begin
      bclkQ <= {bclkQ[0], bclk};
      fsQ   <= {fsQ[0], fsync};
      diQ   <= {diQ[0], serIn};
      bclkD <= bclkS;
      pubD  <= fall && inFrame && (effCnt == rxBits - CNT_W'(1));
      if (fall) begin
        if (fsS) begin
          curW    <= newW;
          curLin  <= linSel;
          running <= 1'b1;
          txCnt   <= '0;
        end
        if (inFrame) rxCnt <= effCnt + CNT_W'(1);
      end
      if (rise && txInFrame) txCnt <= txCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/adpcm_port_dp.sv
module adpcm_port_dp
  import adpcm_port_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  logic [NUM_CH*WORD_W-1:0] txWords,
  output logic                     serOut,
  output logic [NUM_CH*WORD_W-1:0] rxWords,
  output logic                     rxValid
);
  logic [WORD_W-1:0] acc     [NUM_CH];
  logic [WORD_W-1:0] accNext [NUM_CH];
  logic [WORD_W-1:0] txReg   [NUM_CH];
  logic [WORD_W-1:0] rxReg   [NUM_CH];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      accNext[c] = ctl.frameStart ? '0 : acc[c];
      if (ctl.capture && (ctl.rxChan == CH_W'(c)))
        accNext[c] = {accNext[c][WORD_W-2:0], ctl.rxBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        acc[c] <= '0; txReg[c] <= '0; rxReg[c] <= '0;
      end
      rxValid <= 1'b0;
      serOut  <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        acc[c] <= accNext[c];
        if (ctl.frameStart) txReg[c] <= txWords[c*WORD_W +: WORD_W];
        if (ctl.publish)
          rxReg[c] <= ctl.lin ? {{(WORD_W-LIN_BITS){acc[c][LIN_BITS-1]}}, acc[c][LIN_BITS-1:0]}
                              : acc[c];
      end
      rxValid <= ctl.publish;
      if (ctl.launch) serOut <= ctl.txOn ? txReg[ctl.txChan][ctl.txIdx] : 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign rxWords[g*WORD_W +: WORD_W] = rxReg[g];
  end
endmodule

// File: rtl/adpcm_serial_port.sv
module adpcm_serial_port
  import adpcm_port_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bclk,
  input  logic                     fsync,
  input  logic                     serIn,
  input  logic [2:0]               modeSel,
  input  logic                     linSel,
  input  logic [NUM_CH*WORD_W-1:0] txWords,
  output logic                     serOut,
  output logic [NUM_CH*WORD_W-1:0] rxWords,
  output logic                     rxValid
);
  ctl_t ctl;

  adpcm_port_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bclk(bclk), .fsync(fsync), .serIn(serIn),
    .modeSel(modeSel), .linSel(linSel), .ctl(ctl)
  );

  adpcm_port_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txWords(txWords),
    .serOut(serOut), .rxWords(rxWords), .rxValid(rxValid)
  );
endmodule

// File: rtl/adpcm_serial_port_chk.sv
module adpcm_serial_port_chk
  import adpcm_port_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     serOut,
  input logic [NUM_CH*WORD_W-1:0] rxWords,
  input logic                     rxValid,
  input ctl_t                     ctl
);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R3
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> $past(ctl.launch));

  // R6
  width_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctl.width) |-> $past(ctl.frameStart));

  // R2
  edge_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !ctl.launch);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R1
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rxValid && !ctl.lin) |-> (rxWords[g*WORD_W+SLOT_ADPCM +: WORD_W-SLOT_ADPCM] == '0));
    // R8
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rxValid && ctl.lin) |->
        (rxWords[g*WORD_W+WORD_W-1] == rxWords[g*WORD_W+LIN_BITS-1]) &&
        (rxWords[g*WORD_W+WORD_W-2] == rxWords[g*WORD_W+LIN_BITS-1]));
  end
endmodule

bind adpcm_serial_port adpcm_serial_port_chk chk_i (
  .clk(clk), .rstN(rstN), .serOut(serOut), .rxWords(rxWords),
  .rxValid(rxValid), .ctl(ctl)
);

// File: tb/adpcm_serial_port_tb.sv
module adpcm_serial_port_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, serIn = 1'b0, linSel = 1'b0;
  logic [2:0]  modeSel = 3'b000;
  logic [63:0] txWords = '0;
  logic        serOut, rxValid;
  logic [63:0] rxWords;

  int total = 0, bad = 0, validCnt = 0;
  logic [63:0] capWords = '0;

  always #2 clk = ~clk;

  adpcm_serial_port dut_i (
    .clk(clk), .rstN(rstN), .bclk(bclk), .fsync(fsync), .serIn(serIn),
    .modeSel(modeSel), .linSel(linSel), .txWords(txWords),
    .serOut(serOut), .rxWords(rxWords), .rxValid(rxValid)
  );

  always @(negedge clk) if (rxValid) begin
    validCnt++;
    capWords = rxWords;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int expW(input logic [2:0] mode, input logic lin);
    if (lin) return 16;
    case (mode)
      3'b001:  return 3;
      3'b010:  return 2;
      default: return 4;
    endcase
  endfunction

  // one bit time: rising edge with new data, sample serOut, falling edge
  task automatic bitCycle(input logic d, input logic fs, output logic smp);
    @(negedge clk);
    bclk = 1'b1; serIn = d; fsync = fs;
    repeat (HALF) @(negedge clk);
    smp  = serOut;
    bclk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic runFrame(input logic [2:0] mode, input logic lin, input bit flip);
    logic [63:0] stream, gotTx, expTx;
    logic [15:0] txw [4];
    logic [15:0] ev;
    logic s;
    int slot, w, nb, v0;
    stream = {$urandom, $urandom};
    for (int c = 0; c < 4; c++) txw[c] = 16'($urandom);
    slot = lin ? 16 : 4;
    w    = expW(mode, lin);
    nb   = 4 * slot;
    gotTx = '0; expTx = '0;
    modeSel = mode; linSel = lin;
    txWords = {txw[3], txw[2], txw[1], txw[0]};
    v0 = validCnt;
    for (int k = 0; k <= nb + 1; k++) begin
      if (flip && k == nb / 2) begin
        modeSel = (mode == 3'b010) ? 3'b000 : 3'b010;
        linSel  = ~lin;
      end
      bitCycle((k < nb) ? stream[k] : 1'($urandom), k == 0, s);
      if (k >= 1 && k <= nb) gotTx[k-1] = s;
      if (k == nb + 1) chk(s == 1'b0, "R10 idle output", 64'(s), 64'd0);
    end
    chk(validCnt - v0 == 1, "R5 valid pulses per frame", 64'(validCnt - v0), 64'd1);
    for (int c = 0; c < 4; c++) begin
      ev = '0;
      for (int p = 0; p < w; p++) ev = {ev[14:0], stream[c*slot+p]};
      if (lin) ev = {{2{ev[13]}}, ev[13:0]};
      chk(capWords[c*16 +: 16] == ev, "R1 R2 R4 R6 R8 rx word", 64'(capWords[c*16 +: 16]), 64'(ev));
    end
    for (int k = 0; k < nb; k++) begin
      int c = k / slot, p = k % slot;
      expTx[k] = (p < w) ? txw[c][w-1-p] : 1'b0;
    end
    chk(gotTx == expTx, "R3 R4 R9 tx stream", gotTx, expTx);
  endtask

  initial begin
    void'($urandom(32'h5eed_0126));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rxValid == 1'b0, "R10 reset valid", 64'(rxValid), 64'd0);
    chk(rxWords == '0, "R10 reset words", rxWords, 64'd0);
    chk(serOut == 1'b0, "R10 reset output", 64'(serOut), 64'd0);
    // R1 each width, unused code falls back to 4 bits
    runFrame(3'b000, 1'b0, 1'b0);
    runFrame(3'b001, 1'b0, 1'b0);
    runFrame(3'b010, 1'b0, 1'b0);
    runFrame(3'b101, 1'b0, 1'b0);
    runFrame(3'b111, 1'b0, 1'b0);
    // R6 mid-frame mode changes have no effect
    runFrame(3'b000, 1'b0, 1'b1);
    runFrame(3'b001, 1'b0, 1'b1);
    // R8 R9 linear slots
    runFrame(3'b000, 1'b1, 1'b0);
    runFrame(3'b010, 1'b1, 1'b1);
    // R7 32/24 switching on consecutive frames
    for (int i = 0; i < 6; i++) runFrame(i[0] ? 3'b001 : 3'b000, 1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [2:0] m = 3'($urandom);
      runFrame(m, ($urandom % 6) == 0, ($urandom % 4) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule